// File: doc/BRIEF.md
# Register-File Operate Unit with Condition Flags

This block executes the register-to-register operations of a 16-bit load/store machine. It holds eight 16-bit general registers behind two read ports and one write port. From the current instruction word it computes one of three operations: addition, bitwise AND, or bitwise complement. The first operand is a register. The second operand is either another register or a short immediate, sign-extended to the full width.

The result appears on a combinational output and reaches the shared write-back bus outside the block. That bus also carries values read from memory. When the register load enable is high, the bus value is written into the destination register. When the flag load enable is high, three mutually exclusive condition flags (negative, zero, positive) are set from the same bus value.

Every pin is a plain per-cycle control or data signal. The block never stalls, so there is no valid/ready handshake and no back-pressure. Read ports and the result follow the instruction word in the same cycle. Register and flag updates take effect at the next rising clock edge.

Top module: `gpr_alu_unit`

## Requirements
- R1: After reset (rst_n low, active low, asynchronous), every register reads 0 and cond_o equals 3'b010 (Z only).
- R2: rd_a_o shows the register selected by insn_i[8:6] and rd_b_o shows the register selected by insn_i[2:0], both combinationally.
- R3: When reg_we_i is high at a rising edge, wb_bus_i is stored in the register selected by insn_i[11:9]. Without reg_we_i, no register changes.
- R4: If a register is written and read in the same cycle, the read port returns the old value. The new value is visible from the next cycle.
- R5: Opcode 4'h1 in insn_i[15:12] makes alu_res_o the sum, modulo 2^16, of the first operand and the second operand.
- R6: Opcode 4'h5 makes alu_res_o the bitwise AND of the first operand and the second operand.
- R7: Opcode 4'h9 makes alu_res_o the bitwise complement of the first operand. insn_i[5:0] has no effect on the result.
- R8: For opcodes 4'h1 and 4'h5, insn_i[5]=0 selects the register at insn_i[2:0] as the second operand. insn_i[5]=1 selects insn_i[4:0], sign-extended to 16 bits.
- R9: For any other opcode, alu_res_o equals rd_a_o. This pass-through carries store data.
- R10: When flag_we_i is high at a rising edge, cond_o = {N,Z,P} is set from wb_bus_i. N is set when bit 15 is 1. Z is set when the value is zero. P is set otherwise.
- R11: Without flag_we_i, cond_o holds its value. Exactly one bit of cond_o is set in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 16 | Instruction word: op [15:12], destination [11:9], source 1 [8:6], mode [5], source 2 [2:0] / immediate [4:0] |
| wb_bus_i | input | 16 | Write-back bus value |
| reg_we_i | input | 1 | Register load enable |
| flag_we_i | input | 1 | Condition flag load enable |
| rd_a_o | output | 16 | Read port for source 1 |
| rd_b_o | output | 16 | Read port for source 2 |
| alu_res_o | output | 16 | Operation result |
| cond_o | output | 3 | Flags {N,Z,P} |

## Verification
The embedded assertions check the following on every cycle:
- the flags stay one-hot;
- the flags stay stable without their load enable;
- a negative bus value loads N;
- a write reaches the addressed register;
- adding a zero immediate returns the first operand;
- AND of a value with itself returns that value.

Only the bench's scenarios can show the following:
- full arithmetic correctness over every register pair and every immediate value;
- sign extension of each immediate;
- that the complement ignores the low instruction bits;
- the old-value result of a read and a write to the same register in one cycle;
- the pass-through behaviour for the remaining opcodes.

// File: rtl/opx_pkg.sv
package opx_pkg;

  localparam logic [3:0] OPC_ADD = 4'h1;
  localparam logic [3:0] OPC_AND = 4'h5;
  localparam logic [3:0] OPC_NOT = 4'h9;

  typedef struct packed {
    logic neg;
    logic zero;
    logic pos;
  } ccode_t;

  localparam ccode_t CC_RESET = '{neg: 1'b0, zero: 1'b1, pos: 1'b0};

endpackage

// File: rtl/opx_gpr_file.sv
module opx_gpr_file #(
  parameter int DW   = 16,
  parameter int NREG = 8,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [NREG-1:0][DW-1:0] regs;
  logic [NREG-1:0]         wsel;

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_dec
      assign wsel[g] = we && (waddr == AW'(g));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (wsel[i]) regs[i] <= wdata;
      end
    end
  end

  // Reads see the registered state, so a same-cycle write is not visible.
  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];

  p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> regs[$past(waddr)] == $past(wdata));

endmodule

// File: rtl/opx_alu.sv
module opx_alu #(
  parameter int DW    = 16,
  parameter int IMM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       opc,
  input  logic             imm_mode,
  input  logic [IMM_W-1:0] imm,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  output logic [DW-1:0]    res
);
  import opx_pkg::*;

  localparam int EXT_W = DW - IMM_W;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] opnd2;

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign opnd2   = imm_mode ? imm_ext : b;

  always_comb begin
    unique case (opc)
      OPC_ADD: res = a + opnd2;
      OPC_AND: res = a & opnd2;
      OPC_NOT: res = ~a;
      default: res = a;
    endcase
  end

  p_add_zero_imm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_ADD && imm_mode && imm == '0) |-> res == a);

  p_and_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (opc == OPC_AND && !imm_mode && b == a) |-> res == a);

endmodule

// File: rtl/opx_ccode.sv
module opx_ccode #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DW-1:0]   value,
  output opx_pkg::ccode_t flags
);
  import opx_pkg::*;

  ccode_t nxt;

  always_comb begin
    nxt.neg  = value[DW-1];
    nxt.zero = (value == '0);
    nxt.pos  = !value[DW-1] && (value != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flags <= CC_RESET;
    else if (load) flags <= nxt;
  end

  p_flags_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(flags));

  p_neg_loads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && value[DW-1]) |=> flags.neg);

endmodule

// File: rtl/gpr_alu_unit.sv
module gpr_alu_unit #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int IMM_W    = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] insn_i,
  input  logic [15:0] wb_bus_i,
  input  logic        reg_we_i,
  input  logic        flag_we_i,
  output logic [15:0] rd_a_o,
  output logic [15:0] rd_b_o,
  output logic [15:0] alu_res_o,
  output logic [2:0]  cond_o
);
  import opx_pkg::*;

  localparam int AW       = $clog2(NUM_REGS);
  localparam int OPC_LSB  = 12;
  localparam int DST_LSB  = 9;
  localparam int SRC1_LSB = 6;
  localparam int MODE_BIT = 5;
  localparam int SRC2_LSB = 0;

  logic [3:0]        opc;
  logic [AW-1:0]     dst_sel, src1_sel, src2_sel;
  logic [DATA_W-1:0] opa, opb;
  ccode_t            flags;

  assign opc      = insn_i[OPC_LSB +: 4];
  assign dst_sel  = insn_i[DST_LSB +: AW];
  assign src1_sel = insn_i[SRC1_LSB +: AW];
  assign src2_sel = insn_i[SRC2_LSB +: AW];

  opx_gpr_file #(.DW(DATA_W), .NREG(NUM_REGS), .AW(AW)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we_i),
    .waddr   (dst_sel),
    .wdata   (wb_bus_i),
    .raddr_a (src1_sel),
    .raddr_b (src2_sel),
    .rdata_a (opa),
    .rdata_b (opb)
  );

  opx_alu #(.DW(DATA_W), .IMM_W(IMM_W)) u_alu (
    .clk      (clk),
    .rst_n    (rst_n),
    .opc      (opc),
    .imm_mode (insn_i[MODE_BIT]),
    .imm      (insn_i[IMM_W-1:0]),
    .a        (opa),
    .b        (opb),
    .res      (alu_res_o)
  );

  opx_ccode #(.DW(DATA_W)) u_cc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (flag_we_i),
    .value (wb_bus_i),
    .flags (flags)
  );

  assign rd_a_o = opa;
  assign rd_b_o = opb;
  assign cond_o = {flags.neg, flags.zero, flags.pos};

endmodule

// File: tb/gpr_alu_unit_test.sv
module gpr_alu_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] insn = '0;
  logic [15:0] wb = '0;
  logic        reg_we = 1'b0;
  logic        flag_we = 1'b0;
  logic [15:0] rd_a, rd_b, res;
  logic [2:0]  cc;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [8];
  logic [2:0]  cc_model;

  always #4 clk = ~clk;

  gpr_alu_unit uut (
    .clk(clk), .rst_n(rst_n), .insn_i(insn), .wb_bus_i(wb),
    .reg_we_i(reg_we), .flag_we_i(flag_we),
    .rd_a_o(rd_a), .rd_b_o(rd_b), .alu_res_o(res), .cond_o(cc)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] flags_of(input logic [15:0] v);
    if (v[15]) return 3'b100;
    if (v == 16'h0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic write_reg(input int idx, input logic [15:0] val, input logic setcc);
    @(negedge clk);
    insn = {4'h0, 3'(idx), 9'h0};
    wb = val;
    reg_we = 1'b1;
    flag_we = setcc;
    @(negedge clk);
    reg_we = 1'b0;
    flag_we = 1'b0;
    model[idx] = val;
    if (setcc) cc_model = flags_of(val);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] sx, exp;
    cc_model = 3'b010;
    for (int i = 0; i < 8; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      insn = {4'h0, 3'h0, 3'(i), 6'h0};
      #1 check("R1 reg zero", rd_a, 16'h0);
    end
    check("R1 flags", {13'h0, cc}, 16'h0002);
    rst_n = 1'b1;

    // R3 load distinct values (no flag change)
    write_reg(0, 16'h0000, 1'b0);
    write_reg(1, 16'h0001, 1'b0);
    write_reg(2, 16'h7FFF, 1'b0);
    write_reg(3, 16'h8000, 1'b0);
    write_reg(4, 16'hFFFF, 1'b0);
    write_reg(5, 16'h1234, 1'b0);
    write_reg(6, 16'hA5C3, 1'b0);
    write_reg(7, 16'h00F0, 1'b0);
    check("R11 hold without load", {13'h0, cc}, 16'h0002);

    // R2 read ports
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      insn = {4'h0, 3'h0, 3'(i), 3'h0, 3'(7 - i)};
      #1 check("R2 port a", rd_a, model[i]);
      check("R2 port b", rd_b, model[7 - i]);
    end

    // R5/R6/R8 register mode and immediate mode sweep
    for (int op = 0; op < 2; op++) begin
      for (int s1 = 0; s1 < 8; s1++) begin
        for (int s2 = 0; s2 < 8; s2++) begin
          @(negedge clk);
          insn = {(op == 0) ? 4'h1 : 4'h5, 3'h2, 3'(s1), 1'b0, 2'b11, 3'(s2)};
          exp = (op == 0) ? model[s1] + model[s2] : model[s1] & model[s2];
          #1 check(op == 0 ? "R5 add reg R8" : "R6 and reg R8", res, exp);
        end
        for (int im = 0; im < 32; im++) begin
          @(negedge clk);
          insn = {(op == 0) ? 4'h1 : 4'h5, 3'h2, 3'(s1), 1'b1, 5'(im)};
          sx = (im >= 16) ? 16'(im) | 16'hFFE0 : 16'(im);
          exp = (op == 0) ? model[s1] + sx : model[s1] & sx;
          #1 check(op == 0 ? "R5 add imm R8" : "R6 and imm R8", res, exp);
        end
      end
    end

    // R7 complement ignores low bits
    for (int s1 = 0; s1 < 8; s1++) begin
      for (int lo = 0; lo < 64; lo += 9) begin
        @(negedge clk);
        insn = {4'h9, 3'h1, 3'(s1), 6'(lo)};
        #1 check("R7 not", res, ~model[s1]);
      end
    end

    // R9 other opcodes pass first operand
    for (int op = 0; op < 16; op++) begin
      if (op == 1 || op == 5 || op == 9) continue;
      @(negedge clk);
      insn = {4'(op), 3'h0, 3'h6, 1'b1, 5'h1F};
      #1 check("R9 pass", res, model[6]);
    end

    // R4 read during write returns old value
    @(negedge clk);
    insn = {4'h1, 3'h3, 3'h3, 3'h0, 3'h3};
    wb = 16'h5A5A;
    reg_we = 1'b1;
    #1 check("R4 old value", rd_a, 16'h8000);
    @(negedge clk);
    reg_we = 1'b0;
    model[3] = 16'h5A5A;
    #1 check("R4 new value", rd_a, 16'h5A5A);
    check("R3 dest updated", rd_b, 16'h5A5A);

    // R3 no write without enable
    @(negedge clk);
    insn = {4'h0, 3'h5, 3'h5, 6'h0};
    wb = 16'hDEAD;
    @(negedge clk);
    #1 check("R3 no write", rd_a, 16'h1234);

    // R10 flags from bus, R11 hold
    begin
      logic [15:0] vals [6] = '{16'h0000, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h0000};
      for (int k = 0; k < 6; k++) begin
        write_reg(7, vals[k], 1'b1);
        #1 check("R10 flags", {13'h0, cc}, {13'h0, flags_of(vals[k])});
        @(negedge clk);
        wb = 16'h8000;
        flag_we = 1'b0;
        @(negedge clk);
        #1 check("R11 hold", {13'h0, cc}, {13'h0, cc_model});
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule